// File: doc/BRIEF.md
# Two-Level Page Walk and Permission Check

This block performs the last two steps of a 64-bit-entry address translation. Given the base of a directory table and a 32-bit linear address, it reads one 64-bit directory entry over a simple memory port. That entry either maps a 2-MByte region directly or points at a table of 64-bit entries, from which one more entry is read for a 4-KByte page. The block then checks the entries for presence, reserved bits and access rights and returns a physical address or a fault code.

When a translation succeeds, the block sets the accessed flag in every entry it used, and the dirty flag in the final entry on a write. Each of these updates goes back to memory as a full 64-bit write, and only when a flag actually changes. A walk starts with a one-cycle `start` while the block is idle. It ends with a one-cycle `done`, and the result stays on the outputs until the next walk starts.

Top module: `pg_walk_unit`

## Requirements
- R1: After reset `done`, `busy` and `mem_req` are 0 and `fault` is 00. `busy` is 1 from the clock edge that accepts `start` until the cycle after `done`.
- R2: The directory entry is read at {dir_base[M-1:12], lin_addr[29:21], 000}. When its bit 7 is 0, the table entry is read at {dir_entry[M-1:12], lin_addr[20:12], 000}. When bit 7 is 1, no second read is made.
- R3: An entry with bit 0 equal to 0 ends the walk with fault 01. A directory entry like this causes no table read.
- R4: Any of the following ends the walk with fault 11, which takes priority over any permission fault: a nonzero bit in 62:M of either entry, bit 63 set while `xd_en` is 0, or bit 7 set in a table entry.
- R5: A write (`acc_type` 01) faults with 10 when bit 1 of either used entry is 0.
- R6: A user-mode access faults with 10 when bit 2 of either used entry is 0. A supervisor access ignores bit 2.
- R7: With `xd_en` 1, a fetch (`acc_type` 10) faults with 10 when bit 63 of either used entry is 1. Reads are not affected by bit 63.
- R8: On success the fault is 00. The address is {table_entry[M-1:12], lin_addr[11:0]} for a 4-KByte page and {dir_entry[M-1:21], lin_addr[20:0]} for a 2-MByte page. On any fault `phys_addr` and `global_pg` are 0.
- R9: On success, each used entry whose bit 5 is 0 is written back with bit 5 set. The final entry also gets bit 6 set on a write. Each write-back word is the read word with only those bits ORed in. No write is issued when nothing changes, and none on a fault.
- R10: Bit 6 and bits 11:8 of a directory entry that points to a table, and bits 11:9 of a table entry, cause no fault and are never changed.
- R11: `global_pg` equals bit 8 of the final entry ANDed with `glb_en`.
- R12: `done` is high for exactly one cycle per walk. While `mem_ack` is 0, `mem_req`, `mem_we` and `mem_addr` hold steady, and the result is the same for any number of wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken while idle) |
| lin_addr | input | 32 | Linear address to translate |
| dir_base | input | PA_W | Directory table base (bits 11:0 ignored) |
| acc_type | input | 2 | 00 read, 01 write, 10 fetch |
| user_mode | input | 1 | 1 = user-mode access |
| xd_en | input | 1 | Enables bit 63 as execute-disable |
| glb_en | input | 1 | Enables reporting of the global flag |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | PA_W | Byte address of the 64-bit entry |
| mem_wdata | output | 64 | Write-back data |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request accepted this cycle |
| done | output | 1 | One-cycle end-of-walk pulse |
| busy | output | 1 | Walk in progress |
| fault | output | 2 | 00 none, 01 absent, 10 protection, 11 reserved bit |
| phys_addr | output | PA_W | Translated physical address |
| global_pg | output | 1 | Translation is global |

## Verification
A corrupted walk state shows up at the memory port within one cycle. It appears as a read at an address outside the two computed entry addresses, a second read after a large-page entry, or a write on a walk that later ends in a fault. Wrong fault priority or permission decoding shows up in the `fault` code and the zeroed address in the single `done` cycle. A write-back fault shows up in the memory word the bench reads back right after that walk. The vector set puts each level's present, reserved, permission and ignored bits in isolation and in conflicting pairs, so that a priority swap changes the reported code.

// File: rtl/pg_walk_pkg.sv
package pg_walk_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_FETCH = 2'b10
   } acc_e;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'b00,
      FLT_ABSENT = 2'b01,
      FLT_PROT   = 2'b10,
      FLT_RSVD   = 2'b11
   } flt_e;

   localparam int ENT_W   = 64;
   localparam int BIT_P   = 0;
   localparam int BIT_RW  = 1;
   localparam int BIT_US  = 2;
   localparam int BIT_ACC = 5;
   localparam int BIT_DRT = 6;
   localparam int BIT_SZ  = 7;
   localparam int BIT_GLB = 8;
   localparam int BIT_XD  = 63;

   typedef struct packed {
      logic present;
      logic rsv_err;
      logic wr_ok;
      logic usr_ok;
      logic xd_blk;
      logic big;
      logic glb;
   } ent_info_t;

endpackage

// File: rtl/pw_entry_chk.sv
module pw_entry_chk
   import pg_walk_pkg::*;
#(
   parameter int PA_W   = 32,
   parameter bit IS_TBL = 1'b0
) (
   input  logic [ENT_W-1:0] ent,
   input  logic             xd_en,
   output ent_info_t        info
);

   logic hi_rsv;
   logic lvl_rsv;
   logic big_map;
   logic unused_rest;

   generate
      if (PA_W < BIT_XD) begin : g_hi_rsv
         assign hi_rsv = |ent[BIT_XD-1:PA_W];
      end else begin : g_no_hi_rsv
         assign hi_rsv = 1'b0;
      end

      if (IS_TBL) begin : g_tbl_level
         assign lvl_rsv = ent[BIT_SZ];
         assign big_map = 1'b0;
      end else begin : g_dir_level
         assign lvl_rsv = 1'b0;
         assign big_map = ent[BIT_SZ];
      end
   endgenerate

   assign info.present = ent[BIT_P];
   assign info.rsv_err = hi_rsv | lvl_rsv | (ent[BIT_XD] & ~xd_en);
   assign info.wr_ok   = ent[BIT_RW];
   assign info.usr_ok  = ent[BIT_US];
   assign info.xd_blk  = ent[BIT_XD] & xd_en;
   assign info.big     = big_map;
   assign info.glb     = ent[BIT_GLB];

   assign unused_rest  = ^ent;

endmodule

// File: rtl/pw_wb_calc.sv
module pw_wb_calc
   import pg_walk_pkg::*;
(
   input  logic [ENT_W-1:0] ent,
   input  logic             set_dirty,
   output logic [ENT_W-1:0] wdata,
   output logic             need
);

   logic [ENT_W-1:0] mask;

   always_comb begin
      mask          = '0;
      mask[BIT_ACC] = 1'b1;
      mask[BIT_DRT] = set_dirty;
   end

   assign wdata = ent | mask;
   assign need  = (wdata != ent);

endmodule

// File: rtl/pg_walk_unit.sv
module pg_walk_unit
   import pg_walk_pkg::*;
#(
   parameter int PA_W = 32,
   parameter int LA_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LA_W-1:0]  lin_addr,
   input  logic [PA_W-1:0]  dir_base,
   input  logic [1:0]       acc_type,
   input  logic             user_mode,
   input  logic             xd_en,
   input  logic             glb_en,
   output logic             mem_req,
   output logic             mem_we,
   output logic [PA_W-1:0]  mem_addr,
   output logic [63:0]      mem_wdata,
   input  logic [63:0]      mem_rdata,
   input  logic             mem_ack,
   output logic             done,
   output logic             busy,
   output logic [1:0]       fault,
   output logic [PA_W-1:0]  phys_addr,
   output logic             global_pg
);

   localparam int IDX_W = 9;
   localparam int ENT_B = 3;
   localparam int PG_B  = 12;
   localparam int BIG_B = PG_B + IDX_W;
   localparam int TOP_B = BIG_B + IDX_W;

   initial begin
      if (PA_W < 32 || PA_W > 52)
         $error("pg_walk_unit: PA_W must be within 32..52");
      if (LA_W < TOP_B)
         $error("pg_walk_unit: LA_W too small for two index fields");
   end

   typedef enum logic [2:0] {
      ST_IDLE, ST_RD_DIR, ST_RD_TBL, ST_WB_DIR, ST_WB_TBL, ST_DONE
   } st_e;

   st_e              state;
   logic [TOP_B-1:0] lin_q;
   acc_e             acc_q;
   logic             user_q, xd_q, glb_q, large_q;
   logic [63:0]      dir_q, tbl_q;
   logic [PA_W-1:0]  dir_addr_q, tbl_addr_q, pa_q;
   flt_e             fault_q;
   logic             gflag_q;

   logic [63:0]      dir_view, tbl_view;
   ent_info_t        di, ti;
   logic             is_wr, is_fx, dir_bad, tbl_bad;
   logic [63:0]      dir_wdata, tbl_wdata;
   logic             dir_need, tbl_need;
   logic [PA_W-1:0]  tbl_addr_nx, pa_small, pa_big;
   logic             unused_in;

   assign unused_in = ^{dir_base[PG_B-1:0], lin_addr[LA_W-1:TOP_B]};

   assign dir_view = (state == ST_RD_DIR) ? mem_rdata : dir_q;
   assign tbl_view = (state == ST_RD_TBL) ? mem_rdata : tbl_q;

   pw_entry_chk #(.PA_W(PA_W), .IS_TBL(1'b0)) u_dir_chk (
      .ent(dir_view), .xd_en(xd_q), .info(di));

   pw_entry_chk #(.PA_W(PA_W), .IS_TBL(1'b1)) u_tbl_chk (
      .ent(tbl_view), .xd_en(xd_q), .info(ti));

   assign is_wr = (acc_q == ACC_WRITE);
   assign is_fx = (acc_q == ACC_FETCH);

   assign dir_bad = (is_wr & ~di.wr_ok) | (user_q & ~di.usr_ok) | (is_fx & di.xd_blk);
   assign tbl_bad = (is_wr & ~ti.wr_ok) | (user_q & ~ti.usr_ok) | (is_fx & ti.xd_blk);

   pw_wb_calc u_dir_wb (
      .ent(dir_view), .set_dirty(di.big & is_wr), .wdata(dir_wdata), .need(dir_need));

   pw_wb_calc u_tbl_wb (
      .ent(tbl_view), .set_dirty(is_wr), .wdata(tbl_wdata), .need(tbl_need));

   assign tbl_addr_nx = {dir_view[PA_W-1:PG_B], lin_q[BIG_B-1:PG_B], {ENT_B{1'b0}}};
   assign pa_small    = {tbl_view[PA_W-1:PG_B], lin_q[PG_B-1:0]};
   assign pa_big      = {dir_view[PA_W-1:BIG_B], lin_q[BIG_B-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         lin_q      <= '0;
         acc_q      <= ACC_READ;
         user_q     <= 1'b0;
         xd_q       <= 1'b0;
         glb_q      <= 1'b0;
         large_q    <= 1'b0;
         dir_q      <= '0;
         tbl_q      <= '0;
         dir_addr_q <= '0;
         tbl_addr_q <= '0;
         pa_q       <= '0;
         fault_q    <= FLT_NONE;
         gflag_q    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  lin_q      <= lin_addr[TOP_B-1:0];
                  acc_q      <= acc_e'(acc_type);
                  user_q     <= user_mode;
                  xd_q       <= xd_en;
                  glb_q      <= glb_en;
                  dir_addr_q <= {dir_base[PA_W-1:PG_B], lin_addr[TOP_B-1:BIG_B],
                                 {ENT_B{1'b0}}};
                  fault_q    <= FLT_NONE;
                  pa_q       <= '0;
                  gflag_q    <= 1'b0;
                  state      <= ST_RD_DIR;
               end
            end
            ST_RD_DIR: begin
               if (mem_ack) begin
                  dir_q      <= mem_rdata;
                  tbl_addr_q <= tbl_addr_nx;
                  large_q    <= di.big;
                  if (!di.present) begin
                     fault_q <= FLT_ABSENT;
                     state   <= ST_DONE;
                  end else if (di.rsv_err) begin
                     fault_q <= FLT_RSVD;
                     state   <= ST_DONE;
                  end else if (di.big) begin
                     if (dir_bad) begin
                        fault_q <= FLT_PROT;
                        state   <= ST_DONE;
                     end else begin
                        pa_q    <= pa_big;
                        gflag_q <= di.glb & glb_q;
                        state   <= dir_need ? ST_WB_DIR : ST_DONE;
                     end
                  end else begin
                     state <= ST_RD_TBL;
                  end
               end
            end
            ST_RD_TBL: begin
               if (mem_ack) begin
                  tbl_q <= mem_rdata;
                  if (!ti.present) begin
                     fault_q <= FLT_ABSENT;
                     state   <= ST_DONE;
                  end else if (ti.rsv_err) begin
                     fault_q <= FLT_RSVD;
                     state   <= ST_DONE;
                  end else if (dir_bad || tbl_bad) begin
                     fault_q <= FLT_PROT;
                     state   <= ST_DONE;
                  end else begin
                     pa_q    <= pa_small;
                     gflag_q <= ti.glb & glb_q;
                     if (dir_need)
                        state <= ST_WB_DIR;
                     else if (tbl_need)
                        state <= ST_WB_TBL;
                     else
                        state <= ST_DONE;
                  end
               end
            end
            ST_WB_DIR: begin
               if (mem_ack)
                  state <= (!large_q && tbl_need) ? ST_WB_TBL : ST_DONE;
            end
            ST_WB_TBL: begin
               if (mem_ack)
                  state <= ST_DONE;
            end
            ST_DONE:  state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign mem_req   = (state == ST_RD_DIR) || (state == ST_RD_TBL) ||
                      (state == ST_WB_DIR) || (state == ST_WB_TBL);
   assign mem_we    = (state == ST_WB_DIR) || (state == ST_WB_TBL);
   assign mem_addr  = ((state == ST_RD_TBL) || (state == ST_WB_TBL)) ? tbl_addr_q : dir_addr_q;
   assign mem_wdata = (state == ST_WB_TBL) ? tbl_wdata : dir_wdata;
   assign done      = (state == ST_DONE);
   assign busy      = (state != ST_IDLE);
   assign fault     = fault_q;
   assign phys_addr = pa_q;
   assign global_pg = gflag_q;

endmodule

// File: rtl/pg_walk_unit_chk.sv
module pg_walk_unit_chk #(
   parameter int PA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            busy,
   input logic            done,
   input logic            glb_en,
   input logic            mem_req,
   input logic            mem_we,
   input logic            mem_ack,
   input logic [PA_W-1:0] mem_addr,
   input logic [63:0]     mem_wdata,
   input logic [1:0]      fault,
   input logic [PA_W-1:0] phys_addr,
   input logic            global_pg
);

   logic            glb_lat;
   logic            wrote;
   logic [1:0]      rd_cnt;
   logic [PA_W-1:0] rd_a0, rd_a1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_lat <= 1'b0;
         wrote   <= 1'b0;
         rd_cnt  <= '0;
         rd_a0   <= '0;
         rd_a1   <= '0;
      end else begin
         if (start && !busy) begin
            glb_lat <= glb_en;
            wrote   <= 1'b0;
            rd_cnt  <= '0;
         end
         if (mem_req && mem_ack && mem_we)
            wrote <= 1'b1;
         if (mem_req && mem_ack && !mem_we) begin
            rd_cnt <= rd_cnt + 2'd1;
            if (rd_cnt == 2'd0) rd_a0 <= mem_addr;
            else                rd_a1 <= mem_addr;
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                   // R12
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12
   AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault != 2'b00) |-> (phys_addr == '0 && !global_pg));    // R8
   AST_NO_WB_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault != 2'b00) |-> !wrote);                             // R9
   AST_WB_ACC_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[5]);                            // R9
   AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (rd_cnt != 2'd0 &&
                               (mem_addr == rd_a0 || mem_addr == rd_a1))); // R9
   AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (rd_cnt < 2'd2));                        // R2
   AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !glb_lat) |-> !global_pg);                               // R11

endmodule

bind pg_walk_unit pg_walk_unit_chk #(.PA_W(PA_W)) u_walk_chk (.*);

// File: tb/test_pg_walk_unit.sv
module test_pg_walk_unit;

   localparam int  PA_W = 32;
   localparam logic [31:0] LIN = 32'h0060_3ABC;  // dir index 3, table index 3
   localparam int  DIR_IX = 3;
   localparam int  TBL_IX = 512 + 3;               // table base 0x1000

   typedef struct packed {
      logic [63:0] dent;
      logic [63:0] tent;
      logic [1:0]  acc;
      logic        usr;
      logic        xd;
      logic        ge;
      logic [1:0]  xf;
      logic [31:0] xpa;
      logic        xg;
      logic [1:0]  xrd;
      logic [1:0]  xwr;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VT [NV] = '{
      // R8 R9: read, both accessed flags clear
      '{64'h1007, 64'h0ABCD007, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0ABCDABC, 1'b0, 2'd2, 2'd2, 4'd9},
      // R9: write sets dirty only
      '{64'h1027, 64'h0ABCD027, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0ABCDABC, 1'b0, 2'd2, 2'd1, 4'd9},
      // R9: nothing changes, no write
      '{64'h1027, 64'h0ABCD027, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0ABCDABC, 1'b0, 2'd2, 2'd0, 4'd9},
      // R3: directory absent
      '{64'h1006, 64'h0ABCD027, 2'd0, 1'b1, 1'b0, 1'b0, 2'd1, 32'h0, 1'b0, 2'd1, 2'd0, 4'd3},
      // R3: table absent
      '{64'h1027, 64'h0ABCD026, 2'd0, 1'b1, 1'b0, 1'b0, 2'd1, 32'h0, 1'b0, 2'd2, 2'd0, 4'd3},
      // R5: directory read-only, write
      '{64'h1025, 64'h0ABCD027, 2'd1, 1'b1, 1'b0, 1'b0, 2'd2, 32'h0, 1'b0, 2'd2, 2'd0, 4'd5},
      // R6: table supervisor-only, user access
      '{64'h1027, 64'h0ABCD023, 2'd0, 1'b1, 1'b0, 1'b0, 2'd2, 32'h0, 1'b0, 2'd2, 2'd0, 4'd6},
      // R6: same page, supervisor access
      '{64'h1027, 64'h0ABCD023, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0ABCDABC, 1'b0, 2'd2, 2'd0, 4'd6},
      // R4: directory bit 32 set
      '{64'h1_0000_1027, 64'h0ABCD027, 2'd0, 1'b1, 1'b0, 1'b0, 2'd3, 32'h0, 1'b0, 2'd1, 2'd0, 4'd4},
      // R4: table bit 7 set
      '{64'h1027, 64'h0ABCD0A7, 2'd0, 1'b1, 1'b0, 1'b0, 2'd3, 32'h0, 1'b0, 2'd2, 2'd0, 4'd4},
      // R4: reserved beats read-only on a write
      '{64'h1027, 64'h100_0ABC_D025, 2'd1, 1'b1, 1'b0, 1'b0, 2'd3, 32'h0, 1'b0, 2'd2, 2'd0, 4'd4},
      // R7: fetch, execute-disable on
      '{64'h1027, 64'h8000_0000_0ABC_D027, 2'd2, 1'b1, 1'b1, 1'b0, 2'd2, 32'h0, 1'b0, 2'd2, 2'd0, 4'd7},
      // R4: bit 63 while enable off
      '{64'h1027, 64'h8000_0000_0ABC_D027, 2'd2, 1'b1, 1'b0, 1'b0, 2'd3, 32'h0, 1'b0, 2'd2, 2'd0, 4'd4},
      // R7: read unaffected by bit 63
      '{64'h1027, 64'h8000_0000_0ABC_D027, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0, 32'h0ABCDABC, 1'b0, 2'd2, 2'd0, 4'd7},
      // R11: global with enable
      '{64'h1027, 64'h0ABCD127, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0, 32'h0ABCDABC, 1'b1, 2'd2, 2'd0, 4'd11},
      // R11: global without enable
      '{64'h1027, 64'h0ABCD127, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0ABCDABC, 1'b0, 2'd2, 2'd0, 4'd11},
      // R2 R8: 2-MByte page, flags set
      '{64'h126000E7, 64'h0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h12603ABC, 1'b0, 2'd1, 2'd0, 4'd2},
      // R9: 2-MByte page write, accessed and dirty in one word
      '{64'h12600087, 64'h0, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 32'h12603ABC, 1'b0, 2'd1, 2'd1, 4'd9},
      // R10: ignored bits set at both levels
      '{64'h1F67, 64'h0ABCDE27, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0ABCDABC, 1'b0, 2'd2, 2'd0, 4'd10},
      // R6: 2-MByte page supervisor-only, user access
      '{64'h126000E3, 64'h0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd2, 32'h0, 1'b0, 2'd1, 2'd0, 4'd6},
      // R7: 2-MByte page execute-disable, fetch
      '{64'h8000_0000_1260_00E7, 64'h0, 2'd2, 1'b1, 1'b1, 1'b0, 2'd2, 32'h0, 1'b0, 2'd1, 2'd0, 4'd7}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [31:0]     lin_addr = '0;
   logic [PA_W-1:0] dir_base = '0;
   logic [1:0]      acc_type = '0;
   logic            user_mode = 1'b0, xd_en = 1'b0, glb_en = 1'b0;
   logic            mem_req, mem_we, mem_ack, done, busy, global_pg;
   logic [PA_W-1:0] mem_addr, phys_addr;
   logic [63:0]     mem_wdata, mem_rdata;
   logic [1:0]      fault;
   logic            stall = 1'b0;
   logic [63:0]     mem [1024];

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   assign mem_ack   = mem_req & ~stall;
   assign mem_rdata = mem[mem_addr[12:3]];

   pg_walk_unit #(.PA_W(PA_W)) i_pg_walk_unit (
      .clk, .rst_n, .start, .lin_addr, .dir_base, .acc_type, .user_mode,
      .xd_en, .glb_en, .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
      .mem_ack, .done, .busy, .fault, .phys_addr, .global_pg);

   task automatic chk(input string tag, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   int          w_rd, w_wr, w_dn;
   logic        w_busy0;
   logic [1:0]  w_f;
   logic [31:0] w_pa;
   logic        w_g;

   task automatic walk(input vec_t v, input bit use_stall);
      mem[DIR_IX] = v.dent;
      mem[TBL_IX] = v.tent;
      @(negedge clk);
      lin_addr  = LIN;
      acc_type  = v.acc;
      user_mode = v.usr;
      xd_en     = v.xd;
      glb_en    = v.ge;
      start     = 1'b1;
      w_rd = 0; w_wr = 0; w_dn = 0; w_busy0 = 1'b0;
      w_f = '0; w_pa = '0; w_g = 1'b0;
      for (int c = 0; c < 80; c++) begin
         @(negedge clk);
         start = 1'b0;
         stall = use_stall ? ~stall : 1'b0;
         #1;
         if (c == 0) w_busy0 = busy;
         if (mem_req && mem_ack) begin
            if (mem_we) begin
               mem[mem_addr[12:3]] = mem_wdata;
               w_wr++;
            end else begin
               w_rd++;
            end
         end
         if (done) begin
            w_dn++;
            w_f  = fault;
            w_pa = phys_addr;
            w_g  = global_pg;
         end
         if (w_dn != 0 && !done && !busy) break;
      end
      stall = 1'b0;
   endtask

   task automatic check_vec(input vec_t v, input string tag);
      logic [63:0] xd_word, xt_word;
      logic        big;
      big     = v.dent[7];
      xd_word = v.dent;
      xt_word = v.tent;
      if (v.xf == 2'd0) begin
         xd_word = v.dent | 64'h20 | ((big && v.acc == 2'd1) ? 64'h40 : 64'h0);
         if (!big) xt_word = v.tent | 64'h20 | ((v.acc == 2'd1) ? 64'h40 : 64'h0);
      end
      chk(tag, "fault", 64'(w_f), 64'(v.xf));
      chk(tag, "phys_addr", 64'(w_pa), 64'(v.xpa));
      chk(tag, "global", 64'(w_g), 64'(v.xg));
      chk("R2", "reads", 64'(w_rd), 64'(v.xrd));
      chk("R9", "writes", 64'(w_wr), 64'(v.xwr));
      chk("R9/R10", "dir word", mem[DIR_IX], xd_word);
      chk("R9/R10", "tbl word", mem[TBL_IX], xt_word);
      chk("R12", "done count", 64'(w_dn), 64'd1);
      chk("R1", "busy after start", 64'(w_busy0), 64'd1);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state
      chk("R1", "done", 64'(done), 64'd0);
      chk("R1", "busy", 64'(busy), 64'd0);
      chk("R1", "mem_req", 64'(mem_req), 64'd0);
      chk("R1", "fault", 64'(fault), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk("R1", "idle busy", 64'(busy), 64'd0);
      chk("R1", "idle mem_req", 64'(mem_req), 64'd0);

      for (int i = 0; i < NV; i++) begin
         walk(VT[i], 1'b0);
         check_vec(VT[i], $sformatf("R%0d vec%0d", VT[i].rq, i));
      end

      // R12: wait states on every access give the same result
      walk(VT[0], 1'b1);
      check_vec(VT[0], "R12 stalled");

      // R3: absent directory entry leaves memory untouched even with flags clear
      walk(VT[3], 1'b1);
      check_vec(VT[3], "R3 stalled");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(20 * 150000);
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail + 1);
      $finish;
   end

endmodule